// File: doc/BRIEF.md
# Secure Configuration Register Block

This block is a small 32-bit register file on an APB-style slave port. It holds security attribute bits for a few bus masters: two real-time cores, a DMA engine and two USB3 controllers. It also holds a free 32-bit safety-check word. The attribute bits are driven straight out to the fabric that enforces them.

The block has one interrupt source, address-decode error. A status bit records it, and a mask bit gates it onto a level interrupt line. The mask changes only through a pair of write-only strobe registers, one that enables the interrupt and one that disables it. Software can also force the status bit through a trigger register.

Any access to an offset that names no register sets the decode-error status bit. Such an access may also end with a slave error, depending on a control bit. Accesses are whole 32-bit words, and every access completes with no wait states.

Top module: `sec_cfg_regs`

## Requirements
- R1: After reset, every readable register reads zero except the mask register at 0x0C, which reads 1. The interrupt output is low and the security outputs are zero.
- R2: The configuration registers are at these offsets: control at 0x04 (bit 0), core security at 0x20 (bits 1:0), DMA security at 0x24 (bit 0), safety word at 0x30 (all 32 bits) and USB security at 0x34 (bits 1:0). Each keeps only its listed bits, and all other bits read zero.
- R3: The mask register at 0x0C is read-only. Writing 1 to bit 0 at 0x10 clears mask bit 0. Writing 1 to bit 0 at 0x14 sets it. Writing 0 to either has no effect. Offsets 0x10, 0x14 and 0x18 always read zero.
- R4: Status bit 0 sits at 0x08. Writing 1 to it clears it, and writing 0 leaves it unchanged. Writing 1 to bit 0 at 0x18 sets it.
- R5: The interrupt output equals status bit 0 AND NOT mask bit 0. The new level is visible from the clock edge that completes the access which changed either bit.
- R6: An access to an unmapped offset returns read data zero and changes no register except that it sets status bit 0. The unmapped offsets are 0x00, 0x1C, 0x28, 0x2C, 0x38 and 0x3C, plus any address whose low two bits are nonzero.
- R7: The slave-error output is high only during the access phase of an unmapped access while control bit 0 is 1. The ready output is high in every access phase.
- R8: The security outputs always show the contents of the core, DMA and USB security registers. They change only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (6) | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in a read access phase |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Slave error for unmapped accesses |
| irq | output | 1 | Level interrupt, decode error |
| sec_rpu | output | 2 | Security bits for the two real-time cores |
| sec_dma | output | 1 | Security bit for the DMA engine |
| sec_usb | output | 2 | Security bits for the two USB3 controllers |

## Verification
Most of the block's state is visible on readback at the next access. A wrong mask or status bit also shows on the interrupt line one edge after the access that disturbed it. A decode that lets an unmapped offset alias onto a register shows up as a changed readback of that register in the sweep that follows. It also shows as a status bit that stayed clear. The bench writes several data patterns to every word offset in turn. After each write it reads back the whole window and compares against a model, so any corruption is caught within one sweep of the write that caused it.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;

    localparam int DATA_W = 32;

    // byte offsets of the implemented registers
    localparam int OFF_CTRL = 'h04;
    localparam int OFF_STS  = 'h08;
    localparam int OFF_MASK = 'h0C;
    localparam int OFF_EN   = 'h10;
    localparam int OFF_DIS  = 'h14;
    localparam int OFF_TRIG = 'h18;
    localparam int OFF_RPU  = 'h20;
    localparam int OFF_DMA  = 'h24;
    localparam int OFF_SAFE = 'h30;
    localparam int OFF_USB  = 'h34;

    localparam int RPU_W = 2;
    localparam int USB_W = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STS,
        SEL_MASK,
        SEL_EN,
        SEL_DIS,
        SEL_TRIG,
        SEL_RPU,
        SEL_DMA,
        SEL_SAFE,
        SEL_USB
    } reg_sel_e;

    typedef struct packed {
        logic              slverr_en;
        logic [RPU_W-1:0]  rpu;
        logic              dma;
        logic [DATA_W-1:0] safe;
        logic [USB_W-1:0]  usb;
    } cfg_t;

    typedef struct packed {
        logic sts;
        logic mask;
    } irq_state_t;

endpackage

// File: rtl/sec_cfg_decode.sv
module sec_cfg_decode
    import sec_cfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        // misaligned addresses never match an aligned offset
        if      (addr == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFF_STS))  sel = SEL_STS;
        else if (addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
        else if (addr == ADDR_W'(OFF_EN))   sel = SEL_EN;
        else if (addr == ADDR_W'(OFF_DIS))  sel = SEL_DIS;
        else if (addr == ADDR_W'(OFF_TRIG)) sel = SEL_TRIG;
        else if (addr == ADDR_W'(OFF_RPU))  sel = SEL_RPU;
        else if (addr == ADDR_W'(OFF_DMA))  sel = SEL_DMA;
        else if (addr == ADDR_W'(OFF_SAFE)) sel = SEL_SAFE;
        else if (addr == ADDR_W'(OFF_USB))  sel = SEL_USB;
    end

endmodule

// File: rtl/sec_cfg_irq.sv
module sec_cfg_irq
    import sec_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sts_set,
    input  logic sts_clr,
    input  logic mask_set,
    input  logic mask_clr,
    output logic sts,
    output logic mask,
    output logic irq
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a set in the same cycle as a clear wins
        st_d.sts  = (st_q.sts & ~sts_clr) | sts_set;
        st_d.mask = (st_q.mask & ~mask_clr) | mask_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sts  <= 1'b0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts  = st_q.sts;
    assign mask = st_q.mask;
    assign irq  = st_q.sts & ~st_q.mask;

endmodule

// File: rtl/sec_cfg_regs.sv
module sec_cfg_regs
    import sec_cfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]    pwdata,
    output logic [DATA_W-1:0]    prdata,
    output logic                 pready,
    output logic                 pslverr,
    output logic                 irq,
    output logic [RPU_W-1:0]     sec_rpu,
    output logic                 sec_dma,
    output logic [USB_W-1:0]     sec_usb
);

    reg_sel_e sel;
    logic     access, wr_acc, rd_acc, hit;
    logic     sts, mask;
    logic     sts_set, sts_clr, mask_set, mask_clr;
    cfg_t     cfg_d, cfg_q;

    sec_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (paddr),
        .sel  (sel)
    );

    assign access = psel & penable;
    assign wr_acc = access & pwrite;
    assign rd_acc = access & ~pwrite;
    assign hit    = (sel != SEL_NONE);

    assign sts_set  = (access & ~hit) | (wr_acc & (sel == SEL_TRIG) & pwdata[0]);
    assign sts_clr  = wr_acc & (sel == SEL_STS) & pwdata[0];
    assign mask_clr = wr_acc & (sel == SEL_EN)  & pwdata[0];
    assign mask_set = wr_acc & (sel == SEL_DIS) & pwdata[0];

    sec_cfg_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sts_set  (sts_set),
        .sts_clr  (sts_clr),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .sts      (sts),
        .mask     (mask),
        .irq      (irq)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_acc) begin
            unique case (sel)
                SEL_CTRL: cfg_d.slverr_en = pwdata[0];
                SEL_RPU:  cfg_d.rpu       = pwdata[RPU_W-1:0];
                SEL_DMA:  cfg_d.dma       = pwdata[0];
                SEL_SAFE: cfg_d.safe      = pwdata;
                SEL_USB:  cfg_d.usb       = pwdata[USB_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        prdata = '0;
        if (rd_acc) begin
            unique case (sel)
                SEL_CTRL: prdata = DATA_W'(cfg_q.slverr_en);
                SEL_STS:  prdata = DATA_W'(sts);
                SEL_MASK: prdata = DATA_W'(mask);
                SEL_RPU:  prdata = DATA_W'(cfg_q.rpu);
                SEL_DMA:  prdata = DATA_W'(cfg_q.dma);
                SEL_SAFE: prdata = cfg_q.safe;
                SEL_USB:  prdata = DATA_W'(cfg_q.usb);
                default:  prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = access & ~hit & cfg_q.slverr_en;
    assign sec_rpu = cfg_q.rpu;
    assign sec_dma = cfg_q.dma;
    assign sec_usb = cfg_q.usb;

endmodule

// File: rtl/sec_cfg_chk.sv
module sec_cfg_chk
    import sec_cfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              pslverr,
    input logic              irq,
    input logic [RPU_W-1:0]  sec_rpu,
    input logic [USB_W-1:0]  sec_usb
);

    // R7
    slverr_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable));

    // R7
    ready_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable) |-> pready);

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(psel && penable));

    // R5
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(psel && penable && pwrite));

    // R6
    misaligned_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && (paddr[1:0] != 2'b00)) |-> (prdata == '0));

    // R8
    rpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_rpu) |-> $past(psel && penable && pwrite));

    // R8
    usb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_usb) |-> $past(psel && penable && pwrite));

endmodule

bind sec_cfg_regs sec_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .irq     (irq),
    .sec_rpu (sec_rpu),
    .sec_usb (sec_usb)
);

// File: tb/sec_cfg_regs_test.sv
`timescale 1ns/100ps
module sec_cfg_regs_test;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr, irq;
    logic [1:0]    sec_rpu, sec_usb;
    logic          sec_dma;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // model state
    logic       m_ctrl = 0, m_sts = 0, m_mask = 1, m_dma = 0;
    logic [1:0] m_rpu = 0, m_usb = 0;
    logic [31:0] m_safe = 0;

    always #2.5 clk = ~clk;

    sec_cfg_regs #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq(irq),
        .sec_rpu(sec_rpu), .sec_dma(sec_dma), .sec_usb(sec_usb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit mapped(input int a);
        return a == 'h04 || a == 'h08 || a == 'h0C || a == 'h10 || a == 'h14 ||
               a == 'h18 || a == 'h20 || a == 'h24 || a == 'h30 || a == 'h34;
    endfunction

    function automatic string tag_of(input int a);
        if (!mapped(a)) return "R6 unmapped read";
        if (a == 'h08 || a == 'h18) return "R4 status/trigger read";
        if (a == 'h0C || a == 'h10 || a == 'h14) return "R3 mask/strobe read";
        return "R2 config read";
    endfunction

    function automatic logic [31:0] model_rd(input int a);
        case (a)
            'h04: return {31'b0, m_ctrl};
            'h08: return {31'b0, m_sts};
            'h0C: return {31'b0, m_mask};
            'h20: return {30'b0, m_rpu};
            'h24: return {31'b0, m_dma};
            'h30: return m_safe;
            'h34: return {30'b0, m_usb};
            default: return 32'h0;
        endcase
    endfunction

    // one APB transfer; samples in the access phase, returns just after the edge
    task automatic bus(input bit wr, input int a, input logic [31:0] d,
                       output logic [31:0] rd, output logic er, output logic rdy);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = AW'(a); pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; er = pslverr; rdy = pready;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic op(input bit wr, input int a, input logic [31:0] d);
        logic [31:0] rd;
        logic er, rdy;
        logic [31:0] exp_rd;
        logic exp_er;
        exp_rd = model_rd(a);
        exp_er = !mapped(a) && m_ctrl;
        bus(wr, a, d, rd, er, rdy);
        // model update
        if (!mapped(a)) m_sts = 1'b1;
        else if (wr) begin
            case (a)
                'h04: m_ctrl = d[0];
                'h08: if (d[0]) m_sts = 1'b0;
                'h10: if (d[0]) m_mask = 1'b0;
                'h14: if (d[0]) m_mask = 1'b1;
                'h18: if (d[0]) m_sts = 1'b1;
                'h20: m_rpu = d[1:0];
                'h24: m_dma = d[0];
                'h30: m_safe = d;
                'h34: m_usb = d[1:0];
                default: ;
            endcase
        end
        if (!wr) chk(tag_of(a), rd, exp_rd);
        chk("R7 slave error", {31'b0, er}, {31'b0, exp_er});
        chk("R7 ready", {31'b0, rdy}, 32'h1);
        chk("R5 interrupt level", {31'b0, irq}, {31'b0, m_sts & ~m_mask});
        if (wr) chk("R8 security outputs", {27'b0, sec_rpu, sec_dma, sec_usb},
                    {27'b0, m_rpu, m_dma, m_usb});
    endtask

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'h5A5A_A5A5; pats[4] = 32'h0000_0001; pats[5] = 32'h0000_0002;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 security outputs after reset", {27'b0, sec_rpu, sec_dma, sec_usb}, 32'h0);
        for (int a = 4; a < 64; a += 4)
            if (mapped(a)) op(1'b0, a, 32'h0);
        // R4 trigger with mask set: no interrupt; R3 enable raises it
        op(1'b1, 'h18, 32'h1);
        op(1'b1, 'h10, 32'h0);
        op(1'b1, 'h10, 32'h1);
        op(1'b1, 'h08, 32'h0);
        op(1'b1, 'h08, 32'h1);
        // R3 write to mask offset ignored, disable masks again
        op(1'b1, 'h0C, 32'h0);
        op(1'b0, 'h0C, 32'h0);
        op(1'b1, 'h14, 32'h1);
        // R6 misaligned and unmapped reads across the whole window
        op(1'b1, 'h04, 32'h1);
        op(1'b1, 'h10, 32'h1);
        for (int a = 0; a < 64; a++) begin
            op(1'b0, a, 32'h0);
            op(1'b1, 'h08, 32'h1);
        end
        // exhaustive word-offset write sweeps with full readback
        foreach (pats[p]) begin
            for (int w = 0; w < 64; w += 4) begin
                op(1'b1, w, pats[p]);
                for (int r = 0; r < 64; r += 4) op(1'b0, r, 32'h0);
            end
            op(1'b1, 'h04, p[0] ? 32'h1 : 32'h0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule